// File: doc/BRIEF.md
# Bank Precharge Timing Scheduler

This block guards one bank of an SDRAM controller. It watches the activate, read, write and precharge strobes that the controller issues to the bank. From them it works out the earliest clock on which a precharge may legally be issued. Three limits apply: the minimum row-active time since the activate, the end of the most recent read burst, and the write-recovery time after the most recent write burst. The result is a single precharge-permitted flag, so the command sequencer only has to test one bit before it closes the row.

Once a precharge is taken, the block holds the bank busy for the precharge time and then reports it idle again. It also reports how many clocks have passed since the row was opened, and it flags an activate that arrives while the bank is not idle. All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. Every strobe is a single-cycle pulse that is sampled on the rising clock edge.

The write-recovery time is given in picoseconds together with the clock period. The block converts it to clocks at elaboration time and rounds any fraction up. The row-active and precharge times are given directly as clock counts.

Top module: `psched_bank`

## Requirements
- R1: When an activate is accepted at the edge closing cycle A, `pre_ok_o` stays low in every cycle before A+TRAS. If no read or write follows, it rises exactly in cycle A+TRAS.
- R2: For a read taken in cycle T, the last data word is valid in cycle T+CL+BL-1. The precharge point lies one clock before that word for CL 2 and two clocks before it for CL 3, so `pre_ok_o` is low before that point. Encodings: `cl3_i`=0 selects CL 2 and `cl3_i`=1 selects CL 3. `bl_code_i` values 0, 1, 2 and 3 select burst lengths 1, 2, 4 and 8.
- R3: For a write taken in cycle T, the last data word is in cycle T+BL-1. `pre_ok_o` is low before cycle T+BL-1+DPL, where DPL = ceil(TDPL_PS / TCK_PS).
- R4: `pre_ok_o` is the AND of the row-active condition and the burst-end condition. It therefore first rises at the later of the two points.
- R5: `pre_i` is taken only in a cycle where `pre_ok_o` is high. In any other cycle, including while the bank is idle, it has no effect on `bank_idle_o`, `pre_ok_o` or `cyc_cnt_o`.
- R6: After a precharge is taken in cycle P, `bank_idle_o` is low and `pre_ok_o` is low in cycles P+1 to P+TRP-1. `bank_idle_o` is high from cycle P+TRP.
- R7: A read or write taken while an earlier burst is still running replaces it. The burst-end point is then computed from the newest command alone.
- R8: An activate in a cycle where `bank_idle_o` is low raises `err_o` for exactly the following cycle. That activate is otherwise ignored and does not restart the row-active timing.
- R9: `cyc_cnt_o` is 0 while the bank is idle. In cycle A+k after an activate it equals k, and it saturates at 2^CNT_W-1.
- R10: After reset the bank is idle, and `pre_ok_o`, `err_o` and `cyc_cnt_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| act_i | input | 1 | Activate strobe for this bank |
| rd_i | input | 1 | Read command strobe |
| wr_i | input | 1 | Write command strobe (takes priority over rd_i in the same cycle) |
| pre_i | input | 1 | Precharge command strobe |
| cl3_i | input | 1 | CAS latency select: 0 = 2, 1 = 3 |
| bl_code_i | input | 2 | Burst length code: 0/1/2/3 = 1/2/4/8 beats |
| pre_ok_o | output | 1 | Precharge may be issued in this cycle |
| bank_idle_o | output | 1 | Bank is idle and may be activated |
| err_o | output | 1 | Activate seen while bank not idle (one-cycle pulse) |
| cyc_cnt_o | output | CNT_W | Clocks since the row was opened, saturating |

## Verification
The bench builds the block with TRAS=5, TRP=2, TDPL_PS=12000, TCK_PS=10000 and CNT_W=4. The write-recovery ratio is 1.2, so the rounding-up path decides the result, which is 2 clocks. The counter saturates within 20 clocks. The bench sweeps both CAS latencies, all four burst codes, both command types and issue offsets of 0 to 3 clocks after the activate. With these short timings, some cases end their burst well before the row-active limit and others end it well after, so both terms of the AND decide the rising edge in turn. Separate sequences cover a rejected precharge, an illegal activate, a burst replaced in flight and counter saturation.

// File: rtl/psched_pkg.sv
package psched_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OPEN = 2'd1,
    ST_PRE  = 2'd2
  } bank_st_e;

  // Number of data beats selected by the two-bit burst code.
  function automatic int unsigned beats_of(input logic [1:0] code);
    return 32'd1 << code;
  endfunction

  // CAS latency in clocks selected by the latency bit.
  function automatic int unsigned cl_of(input logic cl3);
    return cl3 ? 32'd3 : 32'd2;
  endfunction

endpackage

// File: rtl/psched_down_timer.sv
module psched_down_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

  // R1 / R6 timers: an unloaded nonzero count steps down by one per clock
  p_tmr_step_r1 : assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // Zero is sticky until the next load
  p_tmr_hold_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && zero_o) |=> zero_o);

endmodule

// File: rtl/psched_burst_track.sv
module psched_burst_track
  import psched_pkg::*;
#(
  parameter int W   = 5,
  parameter int DPL = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear_i,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic       cl3_i,
  input  logic [1:0] bl_code_i,
  output logic       done_o
);

  logic [W-1:0] beats;
  logic [W-1:0] cas;
  logic [W-1:0] last_rd;
  logic [W-1:0] lead_rd;
  logic [W-1:0] rd_dist;
  logic [W-1:0] wr_dist;
  logic [W-1:0] ld_val;
  logic         ld;

  always_comb begin
    beats   = W'(beats_of(bl_code_i));
    cas     = W'(cl_of(cl3_i));
    // Last read word relative to the command, then the allowed lead.
    last_rd = cas + beats - W'(1);
    lead_rd = cas - W'(1);
    rd_dist = last_rd - lead_rd;
    // Last write word relative to the command, plus write recovery.
    wr_dist = beats - W'(1) + W'(DPL);
  end

  assign ld = clear_i | rd_i | wr_i;

  always_comb begin
    if (clear_i) begin
      ld_val = '0;
    end else if (wr_i) begin
      ld_val = wr_dist - W'(1);
    end else begin
      ld_val = rd_dist - W'(1);
    end
  end

  psched_down_timer #(.W(W)) u_burst_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (ld),
    .load_val_i (ld_val),
    .zero_o     (done_o)
  );

  // R2: one clock after a read, the end point is reached only for single-beat bursts
  p_rd_done_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !wr_i && !clear_i) |=> (done_o == ($past(bl_code_i) == 2'd0)));

  // R3: a write never completes recovery in the very next cycle when DPL >= 1
  p_wr_busy_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !clear_i && DPL >= 1 && bl_code_i != 2'd0) |=> !done_o);

endmodule

// File: rtl/psched_elapsed_cnt.sv
module psched_elapsed_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         run_i,
  input  logic         clear_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] SAT = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= W'(1);
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (run_i && cnt_q != SAT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  // R9: a saturated count stays put while the row stays open
  p_cnt_sat_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == SAT && run_i && !start_i && !clear_i) |=> (cnt_q == SAT));

  // R9: a start always yields one
  p_cnt_start_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (cnt_q == W'(1)));

endmodule

// File: rtl/psched_bank.sv
module psched_bank
  import psched_pkg::*;
#(
  parameter int TRAS    = 6,
  parameter int TRP     = 3,
  parameter int TDPL_PS = 15000,
  parameter int TCK_PS  = 10000,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic             pre_i,
  input  logic             cl3_i,
  input  logic [1:0]       bl_code_i,
  output logic             pre_ok_o,
  output logic             bank_idle_o,
  output logic             err_o,
  output logic [CNT_W-1:0] cyc_cnt_o
);

  // Write recovery in clocks, fractions rounded up.
  localparam int DPL_CLK   = (TDPL_PS + TCK_PS - 1) / TCK_PS;
  localparam int BURST_MAX = 8 + DPL_CLK;
  localparam int MAX_AB    = (TRAS > TRP) ? TRAS : TRP;
  localparam int MAX_T     = (MAX_AB > BURST_MAX) ? MAX_AB : BURST_MAX;
  localparam int TW        = $clog2(MAX_T + 1);
  localparam int RAS_LOAD  = (TRAS > 0) ? TRAS - 1 : 0;
  localparam int RP_LOAD   = (TRP > 1) ? TRP - 2 : 0;

  bank_st_e st_q, st_d;
  logic     act_take;
  logic     pre_take;
  logic     cmd_en;
  logic     ras_done;
  logic     rp_done;
  logic     burst_done;
  logic     err_q;
  logic     leave_busy;

  assign act_take = act_i && (st_q == ST_IDLE);
  assign cmd_en   = (st_q == ST_OPEN);
  assign pre_ok_o = cmd_en && ras_done && burst_done;
  assign pre_take = pre_i && pre_ok_o;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (act_take) st_d = ST_OPEN;
      ST_OPEN: if (pre_take) st_d = (TRP > 1) ? ST_PRE : ST_IDLE;
      ST_PRE:  if (rp_done)  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= act_i && (st_q != ST_IDLE);
    end
  end

  assign bank_idle_o = (st_q == ST_IDLE);
  assign err_o       = err_q;
  assign leave_busy  = (st_q != ST_IDLE) && (st_d == ST_IDLE);

  psched_down_timer #(.W(TW)) u_ras_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (act_take),
    .load_val_i (TW'(RAS_LOAD)),
    .zero_o     (ras_done)
  );

  psched_down_timer #(.W(TW)) u_rp_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (pre_take),
    .load_val_i (TW'(RP_LOAD)),
    .zero_o     (rp_done)
  );

  psched_burst_track #(.W(TW), .DPL(DPL_CLK)) u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (act_take),
    .rd_i      (rd_i && cmd_en),
    .wr_i      (wr_i && cmd_en),
    .cl3_i     (cl3_i),
    .bl_code_i (bl_code_i),
    .done_o    (burst_done)
  );

  psched_elapsed_cnt #(.W(CNT_W)) u_elapsed (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (act_take),
    .run_i   (st_q != ST_IDLE),
    .clear_i (leave_busy),
    .cnt_o   (cyc_cnt_o)
  );

  // R1: precharge permission implies the row-active time has elapsed
  p_ras_guard_r1 : assert property (@(posedge clk) disable iff (!rst_n)
    pre_ok_o |-> (int'(cyc_cnt_o) >= TRAS || cyc_cnt_o == '1));

  // R6: idle and precharge permission never coexist
  p_idle_excl_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    bank_idle_o |-> !pre_ok_o);

  // R6: a taken precharge keeps the bank busy for at least one clock when TRP > 1
  p_pre_busy_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (pre_take && TRP > 1) |=> (!bank_idle_o && !pre_ok_o));

  // R5: a precharge strobe while idle leaves the bank idle
  p_pre_idle_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (bank_idle_o && pre_i && !act_i) |=> bank_idle_o);

  // R8: an activate while busy raises the error flag next cycle
  p_err_flag_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (act_i && !bank_idle_o) |=> err_o);

  // R8: a legal activate raises no error
  p_err_quiet_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (!act_i || bank_idle_o) |=> !err_o);

  // R9: an accepted activate opens the row with a count of one
  p_open_cnt_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    (act_i && bank_idle_o) |=> (!bank_idle_o && cyc_cnt_o == CNT_W'(1)));

endmodule

// File: tb/psched_bank_bench.sv
module psched_bank_bench;

  localparam int CLK_NS  = 10;
  localparam int TRAS    = 5;
  localparam int TRP     = 2;
  localparam int TDPL_PS = 12000;
  localparam int TCK_PS  = 10000;
  localparam int CNT_W   = 4;
  localparam int DPL     = (TDPL_PS + TCK_PS - 1) / TCK_PS;
  localparam int SAT     = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             act_i = 1'b0;
  logic             rd_i = 1'b0;
  logic             wr_i = 1'b0;
  logic             pre_i = 1'b0;
  logic             cl3_i = 1'b0;
  logic [1:0]       bl_code_i = 2'd0;
  logic             pre_ok_o;
  logic             bank_idle_o;
  logic             err_o;
  logic [CNT_W-1:0] cyc_cnt_o;

  int vec = 0;
  int bad = 0;
  bit finished = 1'b0;

  psched_bank #(
    .TRAS(TRAS), .TRP(TRP), .TDPL_PS(TDPL_PS), .TCK_PS(TCK_PS), .CNT_W(CNT_W)
  ) u_psched_bank (
    .clk(clk), .rst_n(rst_n), .act_i(act_i), .rd_i(rd_i), .wr_i(wr_i),
    .pre_i(pre_i), .cl3_i(cl3_i), .bl_code_i(bl_code_i),
    .pre_ok_o(pre_ok_o), .bank_idle_o(bank_idle_o), .err_o(err_o),
    .cyc_cnt_o(cyc_cnt_o)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input string req, input int got, input int exp);
    vec++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Open the row: activate in cycle 0, return in cycle 1.
  task automatic open_bank();
    act_i = 1'b1;
    tick();
    act_i = 1'b0;
  endtask

  // Scan forward from cycle cyc until pre_ok rises; return that cycle.
  task automatic find_ok(inout int cyc, output int found);
    found = -1;
    while (cyc < 60) begin
      if (pre_ok_o) begin
        found = cyc;
        break;
      end
      tick();
      cyc++;
    end
  endtask

  // Take the precharge now and check the R6 busy window.
  task automatic close_bank();
    pre_i = 1'b1;
    tick();
    pre_i = 1'b0;
    for (int j = 1; j <= TRP; j++) begin
      check("R6 idle", int'(bank_idle_o), (j == TRP) ? 1 : 0);
      check("R6 pre_ok", int'(pre_ok_o), 0);
      if (j < TRP) tick();
    end
    check("R9 idle count", int'(cyc_cnt_o), 0);
  endtask

  initial begin
    #(CLK_NS * 100000);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    int cyc;
    int found;
    int exp;

    repeat (3) tick();
    rst_n = 1'b1;
    // R10 reset state
    check("R10 idle", int'(bank_idle_o), 1);
    check("R10 pre_ok", int'(pre_ok_o), 0);
    check("R10 err", int'(err_o), 0);
    check("R10 count", int'(cyc_cnt_o), 0);
    tick();

    // R2 R3 R4 sweep: latency, burst code, command type, issue offset
    for (int cl = 0; cl < 2; cl++) begin
      for (int bc = 0; bc < 4; bc++) begin
        for (int w = 0; w < 2; w++) begin
          for (int d = 0; d < 4; d++) begin
            int t_cmd;
            int beats;
            int casv;
            int burst_pt;
            cl3_i = cl[0];
            bl_code_i = bc[1:0];
            open_bank();
            repeat (d) tick();
            t_cmd = 1 + d;
            beats = 1 << bc;
            casv = cl ? 3 : 2;
            if (w != 0) begin
              burst_pt = t_cmd + beats - 1 + DPL;
            end else begin
              // last word at t+CL+BL-1, allowed CL-1 clocks earlier
              burst_pt = (t_cmd + casv + beats - 1) - (casv - 1);
            end
            exp = (burst_pt > TRAS) ? burst_pt : TRAS;
            rd_i = (w == 0);
            wr_i = (w != 0);
            tick();
            rd_i = 1'b0;
            wr_i = 1'b0;
            cyc = t_cmd + 1;
            find_ok(cyc, found);
            check((w != 0) ? "R3 write end / R4" : "R2 read end / R4", found, exp);
            check("R9 count at permit", int'(cyc_cnt_o), exp);
            close_bank();
            tick();
          end
        end
      end
    end

    // R5: precharge while idle has no effect
    pre_i = 1'b1;
    tick();
    pre_i = 1'b0;
    check("R5 idle kept", int'(bank_idle_o), 1);
    check("R5 count kept", int'(cyc_cnt_o), 0);

    // R5 and R1: early precharge ignored, then permit exactly at TRAS
    open_bank();
    pre_i = 1'b1;
    tick();
    pre_i = 1'b0;
    check("R5 bank still open", int'(bank_idle_o), 0);
    check("R5 count", int'(cyc_cnt_o), 2);
    cyc = 2;
    find_ok(cyc, found);
    check("R1 no burst permit", found, TRAS);
    close_bank();
    tick();

    // R8: activate while open
    open_bank();
    check("R8 no error yet", int'(err_o), 0);
    act_i = 1'b1;
    tick();
    act_i = 1'b0;
    check("R8 error raised", int'(err_o), 1);
    check("R8 count not restarted", int'(cyc_cnt_o), 2);
    tick();
    check("R8 error one cycle", int'(err_o), 0);
    cyc = 3;
    find_ok(cyc, found);
    check("R8 row timing kept", found, TRAS);
    close_bank();
    tick();

    // R7: long read replaced by a short write
    cl3_i = 1'b0;
    bl_code_i = 2'd3;
    open_bank();
    rd_i = 1'b1;
    tick();
    rd_i = 1'b0;
    bl_code_i = 2'd0;
    wr_i = 1'b1;
    tick();
    wr_i = 1'b0;
    cyc = 3;
    find_ok(cyc, found);
    exp = ((2 + 1 - 1 + DPL) > TRAS) ? (2 + DPL) : TRAS;
    check("R7 newest burst", found, exp);
    close_bank();
    tick();

    // R9: saturation
    open_bank();
    repeat (20) tick();
    check("R9 saturated", int'(cyc_cnt_o), SAT);
    check("R1 permit held", int'(pre_ok_o), 1);
    close_bank();

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

endmodule